// File: doc/BRIEF.md
# UART Receive Buffer and Interrupt Decision Logic

This block sits behind a UART deserializer. Each time the deserializer finishes a framed byte, the block stores it in a receive buffer. It then decides what to tell the rest of the system: raise an interrupt to the CPU, or request a transfer from a DMA engine. The CPU drains the buffer one byte at a time through a read strobe. A DMA engine drains it in fixed four-byte bursts after it acknowledges a request.

The block never hands the DMA engine a partial unit. When a burst ends with one to three bytes still buffered and the line then goes quiet, a receive-timeout interrupt tells the CPU to collect those bytes. A separate end-of-data event marks the pause itself, and it always appears one cycle after the timeout. A character-time tick from the baud logic drives the idle measurement. Line errors and overruns raise a sticky line-status flag. A priority code names the most urgent pending interrupt.

Top module: `uart_rx_irq_ctl`

## Requirements
- R1: Bytes leave the buffer in arrival order. The buffer holds 16 bytes when enabled. `rd_data` always shows the oldest byte. A `rd_en` pulse removes that byte. A `rd_en` pulse while the buffer is empty has no effect.
- R2: In CPU mode, `irq_data` is high while the fill level is at least the trigger level. `cfg_trig` selects the level: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R3: A byte that arrives while the buffer is full is discarded and sets the line-status flag. A byte that arrives with `rx_err` high is stored and also sets the flag. The flag stays set until `lsr_clr` is pulsed.
- R4: The idle counter restarts on every arriving byte and on every removal, and it counts `char_tick` pulses. The threshold is the trigger level in CPU mode and 4 in DMA mode. `irq_tout` rises once 4 ticks have passed with a fill level from 1 up to one less than the threshold. A removal clears it.
- R5: In DMA mode with the buffer enabled, `dma_req` is high while at least 4 bytes are buffered and no burst is running. An acknowledge while `dma_req` is high starts a burst: starting on the next cycle, `dma_beat` is high for exactly 4 cycles and removes one byte per cycle. An acknowledge while `dma_req` is low does nothing.
- R6: In DMA mode, `irq_data` stays low. The end-of-data flag is set one cycle after 4 idle ticks have elapsed, provided at least one byte has been stored since the flag was last set. In that set cycle, any pending `irq_tout` is already visible. The flag stays set until `eord_clr` is pulsed.
- R7: `irq_id` reports the highest pending interrupt: 1 for line status, 2 for timeout, 3 for end-of-data, 4 for data available, 0 for none. `irq` is high exactly when `irq_id` is nonzero.
- R8: With `cfg_fifo_en` low, the buffer holds a single byte, the trigger level is 1, and `dma_req` stays low.
- R9: Each interrupt output is gated by its own enable (`ie_data`, `ie_tout`, `ie_eord`, `ie_lsr`). A disabled source does not appear on `irq` or `irq_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A framed byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | The byte had a framing or parity error |
| char_tick | input | 1 | One pulse per character time |
| cfg_fifo_en | input | 1 | Enable the 16-byte buffer |
| cfg_trig | input | 2 | Receive trigger level code |
| cfg_dma_sel | input | 1 | Select DMA mode |
| ie_data | input | 1 | Enable data-available interrupt |
| ie_tout | input | 1 | Enable receive-timeout interrupt |
| ie_eord | input | 1 | Enable end-of-data interrupt |
| ie_lsr | input | 1 | Enable line-status interrupt |
| rd_en | input | 1 | CPU removes the oldest byte |
| lsr_clr | input | 1 | Clear the line-status flag |
| eord_clr | input | 1 | Clear the end-of-data flag |
| dma_ack | input | 1 | DMA engine accepts a burst |
| rd_data | output | 8 | Oldest buffered byte |
| fifo_level | output | $clog2(DEPTH)+1 | Bytes currently buffered |
| dma_req | output | 1 | Burst request |
| dma_beat | output | 1 | A burst removes `rd_data` this cycle |
| irq_data | output | 1 | Data-available interrupt |
| irq_tout | output | 1 | Receive-timeout interrupt |
| irq_eord | output | 1 | End-of-data interrupt |
| irq_lsr | output | 1 | Line-status interrupt |
| irq | output | 1 | Any enabled interrupt pending |
| irq_id | output | 3 | Highest-priority pending interrupt code |

## Verification
A byte, read, clear or acknowledge takes effect at the rising edge that samples it. From the following cycle on, the fill level, `dma_req` and the level-based interrupts reflect it. `irq_tout` appears in the cycle after the edge that takes the fourth tick, and `irq_eord` appears one cycle later again. The four `dma_beat` cycles begin in the cycle after the acknowledge edge. The bench drives inputs 2 ns after a rising edge and checks flags at that point, once the edge's updates have settled. Popped bytes are compared at the falling edge, before the removing edge, so each check lands in the cycle where the result is due.

// File: rtl/uart_rx_irq_ctl.sv
module uart_rx_irq_ctl #(
  parameter int DEPTH      = 16,
  parameter int IDLE_CHARS = 4,
  parameter int BURST      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_err,
  input  logic                       char_tick,
  input  logic                       cfg_fifo_en,
  input  logic [1:0]                 cfg_trig,
  input  logic                       cfg_dma_sel,
  input  logic                       ie_data,
  input  logic                       ie_tout,
  input  logic                       ie_eord,
  input  logic                       ie_lsr,
  input  logic                       rd_en,
  input  logic                       lsr_clr,
  input  logic                       eord_clr,
  input  logic                       dma_ack,
  output logic [7:0]                 rd_data,
  output logic [$clog2(DEPTH):0]     fifo_level,
  output logic                       dma_req,
  output logic                       dma_beat,
  output logic                       irq_data,
  output logic                       irq_tout,
  output logic                       irq_eord,
  output logic                       irq_lsr,
  output logic                       irq,
  output logic [2:0]                 irq_id
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int IW = $clog2(IDLE_CHARS + 1);
  localparam int BW = $clog2(BURST + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] BURST_C = CW'(BURST);
  localparam logic [IW-1:0] IDLE_C  = IW'(IDLE_CHARS);
  localparam logic [BW-1:0] BEATS_C = BW'(BURST);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, eff_depth, trig_lvl, thr;
  logic [IW-1:0] idle;
  logic [BW-1:0] beats;
  logic          armed, lsr, eord;
  logic          full, push, pop, dma_mode, idle_full, tout_cond, eord_set, lsr_set;

  always_comb begin
    case (cfg_trig)
      2'b00:   trig_lvl = CW'(1);
      2'b01:   trig_lvl = CW'(4);
      2'b10:   trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
    if (!cfg_fifo_en) trig_lvl = CW'(1);
  end

  assign eff_depth = cfg_fifo_en ? DEPTH_C : CW'(1);
  assign full      = cnt >= eff_depth;
  assign push      = rx_valid && !full;
  assign dma_beat  = beats != '0;
  assign pop       = dma_beat || (rd_en && cnt != '0);
  assign dma_mode  = cfg_fifo_en && cfg_dma_sel;
  assign thr       = dma_mode ? BURST_C : trig_lvl;
  assign dma_req   = dma_mode && !dma_beat && cnt >= BURST_C;
  assign idle_full = idle == IDLE_C;
  assign tout_cond = idle_full && cnt != '0 && cnt < thr;
  assign eord_set  = dma_mode && armed && idle_full;
  assign lsr_set   = rx_valid && (full || rx_err);

  assign rd_data    = mem[rp];
  assign fifo_level = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= cfg_fifo_en ? wp + AW'(1) : wp;
      if (pop)  rp <= cfg_fifo_en ? rp + AW'(1) : rp;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats <= '0;
    end else if (dma_beat) begin
      beats <= beats - BW'(1);
    end else if (dma_ack && dma_req) begin
      beats <= BEATS_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= '0;
    end else if (rx_valid || pop) begin
      idle <= '0;
    end else if (char_tick && !idle_full) begin
      idle <= idle + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      eord  <= 1'b0;
      lsr   <= 1'b0;
    end else begin
      if (push)          armed <= 1'b1;
      else if (eord_set) armed <= 1'b0;
      if (eord_set)      eord  <= 1'b1;
      else if (eord_clr) eord  <= 1'b0;
      if (lsr_set)       lsr   <= 1'b1;
      else if (lsr_clr)  lsr   <= 1'b0;
    end
  end

  assign irq_lsr  = ie_lsr && lsr;
  assign irq_tout = ie_tout && tout_cond;
  assign irq_eord = ie_eord && eord;
  assign irq_data = ie_data && !dma_mode && cnt >= trig_lvl;

  always_comb begin
    if (irq_lsr)       irq_id = 3'd1;
    else if (irq_tout) irq_id = 3'd2;
    else if (irq_eord) irq_id = 3'd3;
    else if (irq_data) irq_id = 3'd4;
    else               irq_id = 3'd0;
  end
  assign irq = irq_id != 3'd0;

  p_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !dma_beat && cnt != '0 && !rx_valid |=> cnt == $past(cnt) - CW'(1));

  p_ovf_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && cfg_fifo_en && cnt == DEPTH_C && !rd_en && !dma_beat |=> cnt == $past(cnt) && lsr);

  p_lsr_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_clr && !rx_valid |=> !lsr);

  p_ack_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack |=> dma_beat);

  p_beat_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_beat |-> cnt != '0);

  p_tout_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eord) && tout_cond |-> $past(tout_cond));

  p_single_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en |-> cnt <= CW'(1) && !dma_req);
endmodule

// File: tb/uart_rx_irq_ctl_bench.sv
module uart_rx_irq_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_err = 0, char_tick = 0;
  logic [7:0] rx_data = '0;
  logic cfg_fifo_en = 0, cfg_dma_sel = 0;
  logic [1:0] cfg_trig = 2'b00;
  logic ie_data = 1, ie_tout = 1, ie_eord = 1, ie_lsr = 1;
  logic rd_en = 0, lsr_clr = 0, eord_clr = 0, dma_ack = 0;
  logic [7:0] rd_data;
  logic [4:0] fifo_level;
  logic dma_req, dma_beat, irq_data, irq_tout, irq_eord, irq_lsr, irq;
  logic [2:0] irq_id;

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  logic [7:0] seed = 8'h30;

  always #5 clk = ~clk;

  uart_rx_irq_ctl u_uart_rx_irq_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .char_tick(char_tick), .cfg_fifo_en(cfg_fifo_en), .cfg_trig(cfg_trig),
    .cfg_dma_sel(cfg_dma_sel), .ie_data(ie_data), .ie_tout(ie_tout), .ie_eord(ie_eord),
    .ie_lsr(ie_lsr), .rd_en(rd_en), .lsr_clr(lsr_clr), .eord_clr(eord_clr),
    .dma_ack(dma_ack), .rd_data(rd_data), .fifo_level(fifo_level), .dma_req(dma_req),
    .dma_beat(dma_beat), .irq_data(irq_data), .irq_tout(irq_tout), .irq_eord(irq_eord),
    .irq_lsr(irq_lsr), .irq(irq), .irq_id(irq_id));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic send(bit store, bit err = 1'b0);
    seed = seed + 8'h17;
    rx_data = seed; rx_err = err; rx_valid = 1'b1;
    if (store) exp_q.push_back(seed);
    step();
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1; step(); char_tick = 1'b0;
  endtask

  task automatic pulse_ack();
    dma_ack = 1'b1; step(); dma_ack = 1'b0;
  endtask

  // R1 R5: scoreboard monitor compares each removed byte against the driver's queue
  always @(negedge clk) begin
    if (rst_n && (dma_beat || (rd_en && fifo_level != 0))) begin
      if (exp_q.size() == 0) check("R1 unexpected pop", 32'(rd_data), 32'hFFFF);
      else check("R1 order", 32'(rd_data), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    step(); step();
    check("R7 reset irq_id", 32'(irq_id), 0);
    check("R1 reset level", 32'(fifo_level), 0);
    check("R5 reset dma_req", 32'(dma_req), 0);
    rst_n = 1'b1; step();

    cfg_fifo_en = 1; cfg_trig = 2'b01;
    rd(); check("R1 empty read ignored", 32'(fifo_level), 0);
    repeat (3) send(1);
    check("R2 below trigger", 32'(irq_data), 0);
    send(1);
    check("R2 at trigger 4", 32'(irq_data), 1);
    check("R7 data id", 32'(irq_id), 4);
    ie_data = 0; #1;
    check("R9 data gated", 32'(irq), 0);
    ie_data = 1;
    repeat (4) rd();
    check("R2 drained", 32'(irq_data), 0);

    repeat (2) send(1);
    repeat (3) tick();
    check("R4 three ticks", 32'(irq_tout), 0);
    tick();
    check("R4 four ticks", 32'(irq_tout), 1);
    check("R7 timeout id", 32'(irq_id), 2);
    rd();
    check("R4 read clears", 32'(irq_tout), 0);
    rd();

    cfg_trig = 2'b10;
    repeat (7) send(1);
    check("R2 trigger 8 below", 32'(irq_data), 0);
    send(1);
    check("R2 trigger 8 reached", 32'(irq_data), 1);
    repeat (8) rd();

    cfg_trig = 2'b01;
    repeat (16) send(1);
    check("R3 full no error", 32'(irq_lsr), 0);
    send(0);
    check("R3 overrun level", 32'(fifo_level), 16);
    check("R3 overrun flag", 32'(irq_lsr), 1);
    check("R7 line beats data", 32'(irq_id), 1);
    lsr_clr = 1; step(); lsr_clr = 0;
    check("R3 cleared", 32'(irq_id), 4);
    repeat (16) rd();
    send(1, 1'b1);
    check("R3 error byte kept", 32'(fifo_level), 1);
    check("R3 error flag", 32'(irq_lsr), 1);
    lsr_clr = 1; step(); lsr_clr = 0;
    rd();

    cfg_dma_sel = 1;
    repeat (3) send(1);
    check("R5 no req at 3", 32'(dma_req), 0);
    check("R6 no data irq in dma", 32'(irq_data), 0);
    send(1);
    check("R5 req at 4", 32'(dma_req), 1);
    check("R6 data irq suppressed", 32'(irq_data), 0);
    pulse_ack();
    check("R5 beat after ack", 32'(dma_beat), 1);
    check("R5 req low in burst", 32'(dma_req), 0);
    repeat (4) step();
    check("R5 burst length", 32'(dma_beat), 0);
    check("R5 level after burst", 32'(fifo_level), 0);

    repeat (6) send(1);
    pulse_ack();
    repeat (4) step();
    check("R5 leftover", 32'(fifo_level), 2);
    check("R5 req low below 4", 32'(dma_req), 0);
    repeat (4) tick();
    check("R6 timeout first", 32'(irq_tout), 1);
    check("R6 eord not yet", 32'(irq_eord), 0);
    step();
    check("R6 eord follows", 32'(irq_eord), 1);
    check("R7 timeout over eord", 32'(irq_id), 2);
    repeat (2) rd();
    check("R7 eord id", 32'(irq_id), 3);
    eord_clr = 1; step(); eord_clr = 0;
    check("R6 eord cleared", 32'(irq_id), 0);

    repeat (4) send(1);
    pulse_ack();
    repeat (4) step();
    repeat (4) tick();
    check("R4 aligned no timeout", 32'(irq_tout), 0);
    step();
    check("R6 aligned eord", 32'(irq_eord), 1);
    ie_eord = 0; #1;
    check("R9 eord gated", 32'(irq), 0);
    ie_eord = 1;
    eord_clr = 1; step(); eord_clr = 0;

    send(1);
    pulse_ack();
    check("R5 ack without req", 32'(dma_beat), 0);
    check("R5 level kept", 32'(fifo_level), 1);
    rd();

    cfg_dma_sel = 0; cfg_fifo_en = 0; cfg_trig = 2'b11;
    send(1);
    check("R8 single byte trigger", 32'(irq_data), 1);
    send(0);
    check("R8 single slot", 32'(fifo_level), 1);
    check("R8 overrun", 32'(irq_id), 1);
    lsr_clr = 1; step(); lsr_clr = 0;
    rd();
    check("R1 queue drained", 32'(exp_q.size()), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule